// File: doc/BRIEF.md
# Programmable Trigger Coincidence Unit

This block forms beam-test triggers from four asynchronous discriminator pulses. Each pulse is brought into the system clock domain, reduced to a single rising-edge event, moved later by a per-input delay, and widened by a per-input stretch. The four conditioned levels then address a 16-entry truth table, so any Boolean function of the four inputs can be chosen as the trigger condition. A rising edge of the registered table output produces a single-cycle trigger, unless the busy veto is high.

Every accepted trigger advances a 32-bit counter. The new count and four timestamps are latched together. Each timestamp is the value of a free-running 48-bit cycle counter at that input's most recent synchronised edge. Triggers that arrive during busy are counted in a separate veto counter. All configuration arrives on plain input ports and takes effect on the next clock edge, with no reset needed.

Top module: `trig_coinc_unit`

## Requirements
- R1: After synchronous reset, trig_o is 0 and the accepted count, the veto count, the latched count and all four latched timestamps are 0.
- R2: A raw input passes a two-flop synchroniser and a rising-edge detector. With delay 0, trig_o goes high 3 clock edges after the edge that first samples the input high. An input held high for many cycles gives exactly one event.
- R3: The delay of input i is cfg_delay[5*i+4:5*i] (0 to 31). It postpones that input's event by exactly that many cycles.
- R4: The stretch of input i is cfg_stretch[5*i+4:5*i] = s. The conditioned level stays high for s+1 cycles. A new event while the level is high restarts the full width.
- R5: The table index is the 4-bit vector of conditioned levels, with bit i taken from input i. The trigger condition is cfg_lut[index].
- R6: A trigger is issued only on a 0-to-1 change of the registered table output. trig_o is high for exactly one cycle per such change, however long the condition stays true.
- R7: When the condition rises while busy_i is high, trig_o stays low, the accepted count does not change, and veto_count_o increments by 1.
- R8: Each trigger increments trig_count_o by 1 in the same cycle that trig_o is high. snap_count_o takes the new count value.
- R9: On a trigger, snap_ts_o[48*i+47:48*i] takes the free-running cycle counter value captured at input i's most recent edge. The counter is 0 in the first cycle after reset.
- R10: When cfg_lut is all zeros, no trigger and no veto ever occurs.
- R11: Triggers can be accepted every second cycle, so the only dead time is one cycle per trigger.
- R12: A change of cfg_lut acts on the next clock edge: with the condition already present, trig_o rises 2 edges after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 4 | Asynchronous raw trigger inputs |
| busy_i | input | 1 | Veto for new triggers |
| cfg_delay | input | 20 | Per-input delay, 5 bits each |
| cfg_stretch | input | 20 | Per-input stretch minus one, 5 bits each |
| cfg_lut | input | 16 | Coincidence truth table |
| trig_o | output | 1 | Single-cycle accepted trigger |
| trig_count_o | output | 32 | Accepted trigger count |
| veto_count_o | output | 32 | Vetoed trigger count |
| snap_count_o | output | 32 | Count latched at the last trigger |
| snap_ts_o | output | 192 | Four per-input timestamps latched at the last trigger |

## Verification
A wrong delay tap or a wrong stretch counter shows as a trigger pulse shifted by whole cycles, or as a coincidence appearing or vanishing at an overlap boundary. Comparing trig_o on every clock catches this in the first cycle it differs. A stale edge-detect or table register repeats or drops a trigger, and the count outputs show that on the same edge. A timestamp slipped by one cycle appears in the latched fields at the next trigger. Those fields are therefore checked against the exact edge times the stimulus produced.

// File: rtl/trig_coinc_pkg.sv
package trig_coinc_pkg;

    localparam int NCH   = 4;
    localparam int LUT_W = 1 << NCH;
    localparam int CNT_W = 32;
    localparam int TS_W  = 48;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [TS_W-1:0]  ts_t;
    typedef logic [NCH-1:0]   chvec_t;

    typedef struct packed {
        cnt_t            num;
        ts_t [NCH-1:0]   ts;
    } snap_t;

    function automatic logic lut_pick(input logic [LUT_W-1:0] tbl, input chvec_t idx);
        return tbl[idx];
    endfunction

endpackage

// File: rtl/trig_chan.sv
module trig_chan #(
    parameter int DLY_W = 5,
    parameter int STR_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic [STR_W-1:0] str_i,
    output logic             edge_o,
    output logic             cond_o
);
    localparam int DLY_LEN = 1 << DLY_W;

    logic [2:0]         sync_q;
    logic [DLY_LEN-1:0] tap_q;
    logic [DLY_W-1:0]   tap_idx;
    logic               late_edge;
    logic [STR_W-1:0]   hold_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], raw_i};
    end

    assign edge_o = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) tap_q <= '0;
        else     tap_q <= {tap_q[DLY_LEN-2:0], edge_o};
    end

    assign tap_idx   = dly_i - DLY_W'(1);
    assign late_edge = (dly_i == '0) ? edge_o : tap_q[tap_idx];

    always_ff @(posedge clk) begin
        if (rst)                hold_q <= '0;
        else if (late_edge)     hold_q <= str_i;
        else if (hold_q != '0)  hold_q <= hold_q - STR_W'(1);
    end

    assign cond_o = late_edge | (hold_q != '0);

endmodule

// File: rtl/trig_fire.sv
module trig_fire
    import trig_coinc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  chvec_t           cond_i,
    input  logic [LUT_W-1:0] lut_i,
    output logic             fire_o
);
    logic hit_q, hit_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q      <= 1'b0;
            hit_prev_q <= 1'b0;
        end else begin
            hit_q      <= lut_pick(lut_i, cond_i);
            hit_prev_q <= hit_q;
        end
    end

    assign fire_o = hit_q & ~hit_prev_q;

endmodule

// File: rtl/trig_record.sv
module trig_record
    import trig_coinc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fire_i,
    input  logic   busy_i,
    input  chvec_t edge_i,
    input  ts_t    now_i,
    output logic   trig_o,
    output cnt_t   acc_o,
    output cnt_t   veto_o,
    output snap_t  snap_o
);
    ts_t [NCH-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_o <= 1'b0;
            acc_o  <= '0;
            veto_o <= '0;
            snap_o <= '0;
        end else begin
            trig_o <= fire_i & ~busy_i;
            if (fire_i && busy_i) begin
                veto_o <= veto_o + 1'b1;
            end else if (fire_i) begin
                acc_o      <= acc_o + 1'b1;
                snap_o.num <= acc_o + 1'b1;
                snap_o.ts  <= last_q;
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_last
        always_ff @(posedge clk) begin
            if (rst)            last_q[g] <= '0;
            else if (edge_i[g]) last_q[g] <= now_i;
        end
    end

endmodule

// File: rtl/trig_coinc_unit.sv
module trig_coinc_unit
    import trig_coinc_pkg::*;
#(
    parameter int DLY_W = 5,
    parameter int STR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       trig_in,
    input  logic                 busy_i,
    input  logic [NCH*DLY_W-1:0] cfg_delay,
    input  logic [NCH*STR_W-1:0] cfg_stretch,
    input  logic [LUT_W-1:0]     cfg_lut,
    output logic                 trig_o,
    output logic [CNT_W-1:0]     trig_count_o,
    output logic [CNT_W-1:0]     veto_count_o,
    output logic [CNT_W-1:0]     snap_count_o,
    output logic [NCH*TS_W-1:0]  snap_ts_o
);
    ts_t    now_q;
    chvec_t edge_v, cond_v;
    logic   fire;
    snap_t  snap;

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_q + 1'b1;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        trig_chan #(.DLY_W(DLY_W), .STR_W(STR_W)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (trig_in[g]),
            .dly_i  (cfg_delay[g*DLY_W +: DLY_W]),
            .str_i  (cfg_stretch[g*STR_W +: STR_W]),
            .edge_o (edge_v[g]),
            .cond_o (cond_v[g])
        );
        assign snap_ts_o[g*TS_W +: TS_W] = snap.ts[g];
    end

    trig_fire u_fire (
        .clk    (clk),
        .rst    (rst),
        .cond_i (cond_v),
        .lut_i  (cfg_lut),
        .fire_o (fire)
    );

    trig_record u_rec (
        .clk    (clk),
        .rst    (rst),
        .fire_i (fire),
        .busy_i (busy_i),
        .edge_i (edge_v),
        .now_i  (now_q),
        .trig_o (trig_o),
        .acc_o  (trig_count_o),
        .veto_o (veto_count_o),
        .snap_o (snap)
    );

    assign snap_count_o = snap.num;

endmodule

// File: rtl/trig_coinc_chk.sv
module trig_coinc_chk
    import trig_coinc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy_i,
    input logic [LUT_W-1:0] cfg_lut,
    input logic             trig_o,
    input cnt_t             trig_count_o,
    input cnt_t             veto_count_o,
    input cnt_t             snap_count_o
);
    // R6
    one_cycle_trig_chk: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> !trig_o);

    // R7
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> !$past(busy_i));

    // R7
    veto_step_chk: assert property (@(posedge clk) disable iff (rst)
        (veto_count_o == $past(veto_count_o)) || (veto_count_o == $past(veto_count_o) + 1));

    // R8
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> (trig_count_o == $past(trig_count_o) + 1));

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !trig_o |-> $stable(trig_count_o));

    // R8
    snap_num_chk: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> (snap_count_o == trig_count_o));

    // R10
    zero_table_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_lut == '0 && $past(cfg_lut) == '0 && $past(cfg_lut, 2) == '0) |-> !trig_o);

endmodule

bind trig_coinc_unit trig_coinc_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy_i       (busy_i),
    .cfg_lut      (cfg_lut),
    .trig_o       (trig_o),
    .trig_count_o (trig_count_o),
    .veto_count_o (veto_count_o),
    .snap_count_o (snap_count_o)
);

// File: tb/trig_coinc_unit_tb.sv
module trig_coinc_unit_tb;
    localparam int MAXC = 6000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   trig_in = '0;
    logic         busy_i = 1'b0;
    logic [19:0]  cfg_delay = '0;
    logic [19:0]  cfg_stretch = '0;
    logic [15:0]  cfg_lut = 16'h0002;
    logic         trig_o;
    logic [31:0]  trig_count_o, veto_count_o, snap_count_o;
    logic [191:0] snap_ts_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    trig_coinc_unit u_dut (
        .clk(clk), .rst(rst), .trig_in(trig_in), .busy_i(busy_i),
        .cfg_delay(cfg_delay), .cfg_stretch(cfg_stretch), .cfg_lut(cfg_lut),
        .trig_o(trig_o), .trig_count_o(trig_count_o), .veto_count_o(veto_count_o),
        .snap_count_o(snap_count_o), .snap_ts_o(snap_ts_o)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // reference model: event history per cycle index since reset
    int          c;
    logic [3:0]  raw_h  [0:MAXC];
    logic        bsy_h  [0:MAXC];
    logic [3:0]  edge_h [0:MAXC];
    logic [3:0]  cond_h [0:MAXC];
    logic        hit_h  [0:MAXC];
    longint      m_last [4];
    longint      m_snap [4];
    longint      m_acc, m_veto, m_snapc;
    logic        m_trig;

    always @(posedge clk) begin
        if (rst) begin
            c = 0;
            raw_h[0] = '0; bsy_h[0] = 0; edge_h[0] = '0; cond_h[0] = '0; hit_h[0] = 0;
            m_acc = 0; m_veto = 0; m_snapc = 0; m_trig = 0;
            for (int i = 0; i < 4; i++) begin m_last[i] = 0; m_snap[i] = 0; end
        end else if (c < MAXC - 1) begin
            logic fire_prev;
            c++;
            raw_h[c] = trig_in;
            bsy_h[c] = busy_i;
            for (int i = 0; i < 4; i++) begin
                int d, s;
                edge_h[c][i] = raw_h[c-1][i] & ~((c >= 2) ? raw_h[c-2][i] : 1'b0);
                d = int'(cfg_delay[i*5 +: 5]);
                s = int'(cfg_stretch[i*5 +: 5]);
                cond_h[c][i] = 1'b0;
                for (int q = c - d - s; q <= c - d; q++)
                    if (q >= 1 && edge_h[q][i]) cond_h[c][i] = 1'b1;
            end
            hit_h[c] = cfg_lut[cond_h[c-1]];
            fire_prev = (c >= 2) ? (hit_h[c-1] & ~hit_h[c-2]) : 1'b0;
            m_trig = fire_prev & ~bsy_h[c];
            if (fire_prev && bsy_h[c]) m_veto++;
            if (m_trig) begin
                m_acc++;
                m_snapc = m_acc;
                for (int i = 0; i < 4; i++) m_snap[i] = m_last[i];
            end
            for (int i = 0; i < 4; i++)
                if (edge_h[c-1][i]) m_last[i] = c - 1;
            #1;
            chk(trig_o === m_trig, "R6 trig_o", trig_o, m_trig);
            chk(trig_count_o == 32'(m_acc), "R8 trig_count_o", trig_count_o, m_acc);
            chk(veto_count_o == 32'(m_veto), "R7 veto_count_o", veto_count_o, m_veto);
            chk(snap_count_o == 32'(m_snapc), "R8 snap_count_o", snap_count_o, m_snapc);
            for (int i = 0; i < 4; i++)
                chk(snap_ts_o[i*48 +: 48] == 48'(m_snap[i]), "R9 snap_ts_o",
                    snap_ts_o[i*48 +: 48], m_snap[i]);
        end
    end

    task automatic step(input logic [3:0] v);
        @(negedge clk);
        trig_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) step(4'b0000);
    endtask

    task automatic lat_test(input int ch, input int lat, input string rq);
        step(4'(1 << ch));
        repeat (lat) step(4'b0000);
        chk(trig_o == 1'b0, rq, trig_o, 0);
        step(4'b0000);
        chk(trig_o == 1'b1, rq, trig_o, 1);
        idle(80);
    endtask

    task automatic finish_up;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_up();
        end
    end

    initial begin
        longint base, vbase;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(trig_o == 0 && trig_count_o == 0 && veto_count_o == 0, "R1 reset counters", trig_count_o, 0);
        chk(snap_count_o == 0 && snap_ts_o == '0, "R1 reset snapshot", snap_count_o, 0);
        idle(5);

        // R2 latency with delay 0 and single event for a long pulse
        lat_test(0, 3, "R2 latency");
        base = trig_count_o;
        repeat (30) step(4'b0001);
        idle(80);
        chk(trig_count_o == base + 1, "R2 long pulse one event", trig_count_o, base + 1);

        // R3 delay
        cfg_delay[4:0] = 5'd7;
        idle(2);
        lat_test(0, 10, "R3 delay 7");
        cfg_delay[4:0] = 5'd31;
        idle(2);
        lat_test(0, 34, "R3 delay 31");
        cfg_delay = '0;

        // R4 stretch and overlap boundary (AND of inputs 0 and 1)
        cfg_lut = 16'h0008;
        cfg_stretch[4:0] = 5'd5;
        idle(2);
        base = trig_count_o;
        step(4'b0001); idle(4); step(4'b0010); idle(80);
        chk(trig_count_o == base + 1, "R4 overlap at last stretched cycle", trig_count_o, base + 1);
        base = trig_count_o;
        step(4'b0001); idle(5); step(4'b0010); idle(80);
        chk(trig_count_o == base, "R4 no overlap one past width", trig_count_o, base);
        base = trig_count_o;
        step(4'b0001); idle(3); step(4'b0001); idle(4); step(4'b0010); idle(80);
        chk(trig_count_o == base + 1, "R4 retrigger extends width", trig_count_o, base + 1);
        cfg_stretch = '0;

        // R5 XOR of inputs 0 and 1 (table bits 1 and 2)
        cfg_lut = 16'h0006;
        idle(2);
        base = trig_count_o;
        step(4'b0001); idle(80);
        chk(trig_count_o == base + 1, "R5 xor one input", trig_count_o, base + 1);
        step(4'b0011); idle(80);
        chk(trig_count_o == base + 1, "R5 xor both inputs", trig_count_o, base + 1);
        step(4'b0010); idle(80);
        chk(trig_count_o == base + 2, "R5 xor other input", trig_count_o, base + 2);

        // R11 and R6: trigger every second cycle
        cfg_lut = 16'h0002;
        idle(2);
        base = trig_count_o;
        for (int k = 0; k < 10; k++) begin step(4'b0001); step(4'b0000); end
        idle(80);
        chk(trig_count_o == base + 10, "R11 alternate-cycle triggers", trig_count_o, base + 10);

        // R7 busy veto
        base = trig_count_o; vbase = veto_count_o;
        busy_i = 1'b1;
        for (int k = 0; k < 5; k++) begin step(4'b0001); idle(9); end
        idle(80);
        chk(trig_count_o == base, "R7 busy blocks count", trig_count_o, base);
        chk(veto_count_o == vbase + 5, "R7 veto counted", veto_count_o, vbase + 5);
        busy_i = 1'b0;

        // R9 per-input timestamps, four-fold coincidence
        cfg_lut = 16'h8000;
        cfg_stretch = {4{5'd31}};
        idle(2);
        base = trig_count_o;
        for (int k = 0; k < 12; k++) begin
            logic [3:0] v;
            v = '0;
            if (k == 0) v[0] = 1'b1;
            if (k == 3) v[1] = 1'b1;
            if (k == 5) v[2] = 1'b1;
            if (k == 9) v[3] = 1'b1;
            step(v);
        end
        idle(100);
        chk(trig_count_o == base + 1, "R9 four-fold trigger", trig_count_o, base + 1);
        chk(snap_ts_o[48 +: 48] - snap_ts_o[0 +: 48] == 3, "R9 ts1-ts0",
            snap_ts_o[48 +: 48] - snap_ts_o[0 +: 48], 3);
        chk(snap_ts_o[96 +: 48] - snap_ts_o[0 +: 48] == 5, "R9 ts2-ts0",
            snap_ts_o[96 +: 48] - snap_ts_o[0 +: 48], 5);
        chk(snap_ts_o[144 +: 48] - snap_ts_o[0 +: 48] == 9, "R9 ts3-ts0",
            snap_ts_o[144 +: 48] - snap_ts_o[0 +: 48], 9);
        chk(snap_count_o == trig_count_o, "R8 snapshot count", snap_count_o, trig_count_o);

        // R10 zero table
        cfg_lut = 16'h0000;
        idle(2);
        base = trig_count_o; vbase = veto_count_o;
        step(4'b1111); idle(3); step(4'b0101); idle(3); step(4'b1010); idle(80);
        chk(trig_count_o == base && veto_count_o == vbase, "R10 zero table silent", trig_count_o, base);

        // R12 table change acts next edge
        cfg_stretch = '0;
        cfg_stretch[4:0] = 5'd31;
        idle(2);
        step(4'b0001);
        idle(8);
        cfg_lut = 16'h0002;
        step(4'b0000);
        chk(trig_o == 1'b0, "R12 one edge after change", trig_o, 0);
        step(4'b0000);
        chk(trig_o == 1'b1, "R12 two edges after change", trig_o, 1);
        idle(80);

        done = 1;
        finish_up();
    end
endmodule